// File: doc/BRIEF.md
# Multiprocessor-Format Asynchronous Serial Transmitter

This block serializes bytes onto an asynchronous serial line. Each frame carries a ninth bit, chosen by the host for every byte, in the slot that parity would otherwise take. A 1 in that bit marks the byte as a station address. A 0 marks the byte as payload for whichever station was addressed last. The block never sends a parity bit. A bit period lasts from one pulse of `baud_tick` to the next. The divider that makes those pulses sits outside the block.

The host uses a one-entry holding register and a flag, `tx_empty`. While the flag reads 1, the host writes a byte together with its ninth bit, then pulses `clr_empty` to hand the byte over. The shifter takes the byte at the next baud tick on which it is free, and it raises the flag again on that same tick. This means the next byte can be queued while the current frame is still going out, and frames follow one another with no idle gap. Dropping `tx_en` halts the shifter, and the line is then driven from `brk_val`. Holding `brk_val` at 0 sends a break.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset, `txd` is 1 (idle) and `tx_empty` is 1.
- R2: A frame goes out least significant bit first, in this order: a start bit of 0, the data bits, the multiprocessor bit, then stop bits of 1. No parity bit is sent.
- R3: `fmt_sel[1]`=1 selects 7 data bits (byte bit 7 is not sent) and 0 selects 8. `fmt_sel[0]`=1 selects 2 stop bits and 0 selects 1. The format is sampled when a frame starts.
- R4: The bit that directly follows the last data bit equals the `wr_mpb` value written with that byte: 1 for an address frame, 0 for a data frame.
- R5: A pulse of `wr_en` while `tx_empty` is 0 has no effect, and the byte already queued is sent unchanged.
- R6: A pulse of `clr_empty` while `tx_empty` is 1 drops the flag on the next cycle. The flag returns to 1 on the baud tick that loads the frame, which is the same cycle in which the start bit appears on `txd`.
- R7: If a byte is queued before the current frame ends, its start bit directly follows the last stop bit, with no idle bit between them.
- R8: While `tx_en` is high, each frame bit is held from one baud tick to the next, and `txd` changes only in cycles with `baud_tick` high.
- R9: While `tx_en` is 0, `txd` equals `brk_val` one cycle later, and no frame starts (a queued byte keeps `tx_empty` at 0). When `tx_en` returns to 1, the queued byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse that marks each bit period |
| tx_en | input | 1 | Transmit enable; when low, the shifter halts and the override drives the line |
| brk_val | input | 1 | Line level driven while `tx_en` is low (0 gives a break) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_byte | input | DW | Byte to send |
| wr_mpb | input | 1 | Multiprocessor bit for this byte (1 = address, 0 = data) |
| clr_empty | input | 1 | Clears the empty flag to hand over the byte |
| fmt_sel | input | 2 | Frame format: bit 1 selects 7 data bits, bit 0 selects 2 stop bits |
| tx_empty | output | 1 | Holding register empty flag |
| txd | output | 1 | Serial line, registered |

## Verification
Two functions can fall in the same cycle: the shifter taking the holding register on a baud tick while it finishes the previous stop bit, and the host writing the next byte. To provoke this, bytes are queued continuously in every format, so each take coincides with the end of a frame. A write is also made while a byte is still queued. The results are judged from the recorded line. Each new start bit must sit exactly where the previous frame ended. The queued byte must come out unchanged, not the byte from the stray write. A break test holds a queued byte behind a low `tx_en` and then checks that the byte is sent intact once `tx_en` returns.

// File: rtl/mptx_pkg.sv
package mptx_pkg;

  typedef struct packed {
    logic seven;     // 7 data bits instead of DW
    logic two_stop;  // two stop bits instead of one
  } fmt_t;

  // number of line bits in one frame: start + data + mp bit + stops
  function automatic int unsigned frame_bits(input int unsigned dw,
                                             input logic seven,
                                             input logic two_stop);
    return 1 + (seven ? dw - 1 : dw) + 1 + (two_stop ? 2 : 1);
  endfunction

endpackage

// File: rtl/mptx_hold.sv
module mptx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          clr,
  input  logic          take,
  input  logic [DW-1:0] wdata,
  input  logic          wmpb,
  output logic [DW-1:0] hdata,
  output logic          hmpb,
  output logic          empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdata <= '0;
      hmpb  <= 1'b0;
      empty <= 1'b1;
    end else begin
      // the host may only load while the flag is set
      if (wr && empty) begin
        hdata <= wdata;
        hmpb  <= wmpb;
      end
      // take needs empty=0 and clr acts only on empty=1: never both
      if (take)
        empty <= 1'b1;
      else if (clr && empty)
        empty <= 1'b0;
    end
  end

endmodule

// File: rtl/mptx_shift.sv
module mptx_shift
  import mptx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          brk,
  input  logic          pending,
  input  logic [DW-1:0] hdata,
  input  logic          hmpb,
  input  fmt_t          fmt,
  output logic          take,
  output logic          txd
);

  localparam int FW = DW + 4;            // start + DW data + mp + 2 stops
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] left_q;
  logic          txd_q;
  logic [FW-1:0] frame;
  logic [CW-1:0] flen;

  // frame image, bit 0 leaves first; unused upper stop slots are 1
  always_comb begin
    if (fmt.seven)
      frame = {3'b111, hmpb, hdata[DW-2:0], 1'b0};
    else
      frame = {2'b11, hmpb, hdata, 1'b0};
    flen = CW'(frame_bits(DW, fmt.seven, fmt.two_stop));
  end

  assign take = tick && en && (left_q == '0) && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      txd_q  <= 1'b1;
    end else if (!en) begin
      sh_q   <= '1;
      left_q <= '0;
      txd_q  <= brk;
    end else if (take) begin
      txd_q  <= frame[0];
      sh_q   <= {1'b1, frame[FW-1:1]};
      left_q <= flen - 1'b1;
    end else if (tick && (left_q != '0)) begin
      txd_q  <= sh_q[0];
      sh_q   <= {1'b1, sh_q[FW-1:1]};
      left_q <= left_q - 1'b1;
    end else if (left_q == '0) begin
      txd_q  <= 1'b1;
    end
  end

  assign txd = txd_q;

endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mptx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic          brk_val,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_byte,
  input  logic          wr_mpb,
  input  logic          clr_empty,
  input  logic [1:0]    fmt_sel,
  output logic          tx_empty,
  output logic          txd
);

  logic [DW-1:0] hdata;
  logic          hmpb;
  logic          take;
  fmt_t          fmt;

  assign fmt = fmt_t'(fmt_sel);

  mptx_hold #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_en),
    .clr   (clr_empty),
    .take  (take),
    .wdata (wr_byte),
    .wmpb  (wr_mpb),
    .hdata (hdata),
    .hmpb  (hmpb),
    .empty (tx_empty)
  );

  mptx_shift #(.DW(DW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick),
    .en      (tx_en),
    .brk     (brk_val),
    .pending (!tx_empty),
    .hdata   (hdata),
    .hmpb    (hmpb),
    .fmt     (fmt),
    .take    (take),
    .txd     (txd)
  );

endmodule

// File: rtl/mp_uart_tx_chk.sv
module mp_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic tx_en,
  input logic brk_val,
  input logic clr_empty,
  input logic tx_empty,
  input logic txd
);

  // R6: the flag only drops after a clear request
  a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_empty) |-> $past(clr_empty));

  // R6: the flag only returns on an enabled baud tick
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> ($past(baud_tick) && $past(tx_en)));

  // R2: the start bit appears in the cycle the flag returns
  a_r2_start_at_load: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> (txd == 1'b0));

  // R9: with transmit disabled the line follows the override
  a_r9_break_follows: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (txd == $past(brk_val)));

  // R8: no line change between ticks while enabled
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en) && !baud_tick) |=> $stable(txd));

endmodule

bind mp_uart_tx mp_uart_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud_tick (baud_tick),
  .tx_en     (tx_en),
  .brk_val   (brk_val),
  .clr_empty (clr_empty),
  .tx_empty  (tx_empty),
  .txd       (txd)
);

// File: tb/sim_mp_uart_tx.sv
module sim_mp_uart_tx;
  localparam int CLK_P = 10;
  localparam int BD    = 4;
  localparam int NBITS = 16384;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       tx_en = 1'b1;
  logic       brk_val = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       wr_mpb = 1'b0;
  logic       clr_empty = 1'b0;
  logic [1:0] fmt_sel = 2'b00;
  logic       tx_empty;
  logic       txd;

  int n_chk = 0;
  int n_bad = 0;
  logic bits [0:NBITS-1];
  int nb = 0;
  int ptr = 0;
  int gap_end = 0;

  always #(CLK_P/2) clk = ~clk;

  mp_uart_tx #(.DW(8)) u0 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_val(brk_val), .wr_en(wr_en), .wr_byte(wr_byte), .wr_mpb(wr_mpb),
    .clr_empty(clr_empty), .fmt_sel(fmt_sel), .tx_empty(tx_empty), .txd(txd)
  );

  // baud pulses; the line is recorded once per bit, after the tick edge
  initial begin
    forever begin
      repeat (BD - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      if (nb < NBITS) begin
        bits[nb] = txd;
        nb++;
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // queue one byte: write and clear together once the flag is 1
  task automatic send(input logic [7:0] b, input logic m);
    while (!tx_empty) @(negedge clk);
    wr_en = 1'b1; wr_byte = b; wr_mpb = m; clr_empty = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; clr_empty = 1'b0;
    check(tx_empty == 1'b0, "R6 flag drop", 32'(tx_empty), 32'd0);
  endtask

  task automatic drain();
    while (!tx_empty) @(negedge clk);
    repeat (BD * 14) @(negedge clk);
  endtask

  // find the next start bit in the record and compare one frame
  task automatic expect_frame(input logic [7:0] b, input logic m,
                              input logic [1:0] f, input bit gap);
    int nd;
    int len;
    logic [15:0] e;
    logic [15:0] a;
    nd  = f[1] ? 7 : 8;
    len = 2 + nd + (f[0] ? 2 : 1);
    e = '1;
    a = '1;
    while (ptr < nb && bits[ptr] !== 1'b0) ptr++;
    if (gap) check(ptr == gap_end, "R7 no idle gap", 32'(ptr), 32'(gap_end));
    e[0] = 1'b0;
    for (int i = 0; i < nd; i++) e[1+i] = b[i];
    e[1+nd] = m;
    for (int i = 0; i < len; i++) a[i] = (ptr + i < nb) ? bits[ptr+i] : 1'bx;
    check(a === e, "R2 R3 R8 frame bits", 32'(a), 32'(e));
    check(a[1+nd] === m, "R4 mp bit", 32'(a[1+nd]), 32'(m));
    ptr = ptr + len;
    gap_end = ptr;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] qb [0:17];
    logic       qm [0:17];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(tx_empty == 1'b1, "R1 empty after reset", 32'(tx_empty), 32'd1);
    check(txd == 1'b1, "R1 idle line", 32'(txd), 32'd1);
    repeat (BD * 2) @(negedge clk);
    ptr = nb;

    // sweep every format with a continuous stream of frames
    for (int f = 0; f < 4; f++) begin
      fmt_sel = 2'(f);
      qb[0] = 8'h01; qm[0] = 1'b1;
      qb[1] = 8'hAA; qm[1] = 1'b0;
      for (int i = 2; i < 18; i++) begin
        qb[i] = 8'(i * 29 + f * 61 + 3);
        qm[i] = 1'(i[0] ^ f[0]);
      end
      for (int i = 0; i < 18; i++) send(qb[i], qm[i]);
      drain();
      for (int i = 0; i < 18; i++) expect_frame(qb[i], qm[i], 2'(f), i > 0);
    end

    // R5: stray write while a byte is still queued
    fmt_sel = 2'b00;
    send(8'h3C, 1'b0);
    send(8'hC3, 1'b1);
    check(tx_empty == 1'b0, "R5 queued", 32'(tx_empty), 32'd0);
    wr_en = 1'b1; wr_byte = 8'h99; wr_mpb = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    drain();
    expect_frame(8'h3C, 1'b0, 2'b00, 1'b0);
    expect_frame(8'hC3, 1'b1, 2'b00, 1'b1);
    begin
      int extra;
      extra = 0;
      for (int i = ptr; i < nb; i++) if (bits[i] !== 1'b1) extra++;
      check(extra == 0, "R5 no extra frame", 32'(extra), 32'd0);
    end

    // R9: break and held byte
    tx_en = 1'b0; brk_val = 1'b0;
    @(negedge clk);
    check(txd == 1'b0, "R9 break low", 32'(txd), 32'd0);
    brk_val = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R9 override high", 32'(txd), 32'd1);
    brk_val = 1'b0;
    send(8'h81, 1'b1);
    repeat (BD * 12) @(negedge clk);
    check(tx_empty == 1'b0, "R9 no start while disabled", 32'(tx_empty), 32'd0);
    check(txd == 1'b0, "R9 break held", 32'(txd), 32'd0);
    brk_val = 1'b1;
    repeat (BD * 2 + 2) @(negedge clk);
    ptr = nb;
    tx_en = 1'b1;
    drain();
    expect_frame(8'h81, 1'b1, 2'b00, 1'b0);
    check(tx_empty == 1'b1, "R6 flag back after resume", 32'(tx_empty), 32'd1);

    summary();
    $finish;
  end

endmodule